// File: doc/BRIEF.md
# Per-Period Pulse Placement Modulator

This block drives a single pulse line with one pulse in each output period. A period is made of 64 slots of the fast block clock. The pulse is high for as many slots as a 6-bit unsigned width word asks for. Two control lines choose where the pulse sits in the period: at the start, at the end, or centred on the middle slot. A new width and placement can be given for every period, so both can change from one period to the next.

The width word and the controls are sampled into a holding register at each period boundary. Changes on those inputs inside a period do not disturb the pulse in progress. A line-start strobe restarts the slot count so that period boundaries follow an external line timing. The output is registered and lags the slot counter by one clock. This gives a fixed delay from each captured word to its pulse, and the pulses come out in the same order the words were given.

Top module: `pulse_place_mod`

## Requirements
- R1: With `ctl_centre`=0 and `ctl_trail`=0 (leading), a captured width N drives `pwm_out` high for slots 0 to N-1 of the period and low for the other slots.
- R2: With `ctl_centre`=0 and `ctl_trail`=1 (trailing), a captured width N drives `pwm_out` high for slots 64-N to 63 and low for the other slots.
- R3: With `ctl_centre`=1 (centred), a captured width N drives `pwm_out` high from slot 32-floor(N/2) up to slot 31+ceil(N/2). An odd N therefore puts its extra slot after the middle.
- R4: Each period holds exactly N high slots. A width of 0 gives no high slot in any placement.
- R5: The width word, with bit 0 as least significant, and the controls are captured on the clock when the slot counter is at slot 63, or when `line_start` is high. They govern the next 64 slots. The value for slot k appears on `pwm_out` one clock after the counter is at slot k. Successive words produce successive periods in order, with none skipped or repeated.
- R6: Changes to `data_word`, `ctl_centre` or `ctl_trail` between capture points have no effect on the pulse of the current period.
- R7: When `line_start` is high on a clock edge, the slot counter goes to slot 0 at that edge and the inputs are captured as for a new period, whatever slot the counter was in.
- R8: `pwm_out` is low while `rst` is high. It stays low for the first 64 slots after reset, until the first word has been captured.
- R9: When `ctl_centre`=1, the value of `ctl_trail` does not affect the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast slot clock |
| rst | input | 1 | Synchronous reset, active high |
| data_word | input | 6 | Pulse width in slots, bit 0 least significant |
| ctl_centre | input | 1 | 1 selects centred placement, 0 selects single-edge |
| ctl_trail | input | 1 | In single-edge placement, 0 selects leading and 1 selects trailing |
| line_start | input | 1 | Restarts the slot counter at slot 0 and captures a new word |
| pwm_out | output | 1 | Registered pulse output |

## Verification
The hardest case to reach from the ports is a line-start strobe that arrives partway through a period. It must cut the running period short, capture a fresh word and realign every boundary after it. The stimulus runs one scored stream of periods, lets the counter drift 23 slots into a period that is not scored, and then starts a second stream with a strobe. Every slot of the periods after the strobe is compared against patterns computed in the bench. In each period the bench also inverts the width and both controls halfway through, so that any leak from the inputs into a pulse in progress shows up.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

   typedef enum logic [1:0] {
      PLACE_LEAD   = 2'd0,
      PLACE_TRAIL  = 2'd1,
      PLACE_CENTRE = 2'd2
   } place_e;

   // centre bit dominates; trail bit only matters for single-edge placement
   function automatic place_e decode_place(input logic centre, input logic trail);
      if (centre)     return PLACE_CENTRE;
      else if (trail) return PLACE_TRAIL;
      else            return PLACE_LEAD;
   endfunction

endpackage

// File: rtl/ppm_slot_counter.sv
module ppm_slot_counter #(
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_start,
   output logic [DATA_W-1:0] slot,
   output logic              boundary
);
   localparam logic [DATA_W-1:0] LAST_SLOT = '1;

   logic last;

   assign last     = (slot == LAST_SLOT);
   assign boundary = last | line_start;

   always_ff @(posedge clk) begin
      if (rst)             slot <= '0;
      else if (line_start) slot <= '0;
      else                 slot <= slot + 1'b1;
   end

   a_r7_restart_slot0: assert property (@(posedge clk) disable iff (rst)
      line_start |=> (slot == '0));

   a_r5_wrap_after_last: assert property (@(posedge clk) disable iff (rst)
      (last && !line_start) |=> (slot == '0));

   a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
      (!boundary && !$past(rst)) |=> (slot == $past(slot) + 1'b1));

endmodule

// File: rtl/ppm_word_hold.sv
module ppm_word_hold
   import ppm_pkg::*;
#(
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] data_in,
   input  logic              centre_in,
   input  logic              trail_in,
   output logic [DATA_W-1:0] width_q,
   output place_e            place_q,
   output logic              valid_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         width_q <= '0;
         place_q <= PLACE_LEAD;
         valid_q <= 1'b0;
      end else if (load) begin
         width_q <= data_in;
         place_q <= decode_place(centre_in, trail_in);
         valid_q <= 1'b1;
      end
   end

   a_r5_load_word: assert property (@(posedge clk) disable iff (rst)
      load |=> (width_q == $past(data_in)) && valid_q);

   a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
      (!load && !$past(rst)) |=> ($stable(width_q) && $stable(place_q)));

   a_r9_centre_dominates: assert property (@(posedge clk) disable iff (rst)
      (load && centre_in) |=> (place_q == PLACE_CENTRE));

endmodule

// File: rtl/ppm_window_cmp.sv
module ppm_window_cmp
   import ppm_pkg::*;
#(
   parameter int DATA_W    = 6,
   parameter bit LATE_BIAS = 1'b1
) (
   input  logic [DATA_W-1:0] slot,
   input  logic [DATA_W-1:0] width,
   input  place_e            place,
   input  logic              valid,
   output logic              hit
);
   localparam int EW    = DATA_W + 1;
   localparam int SLOTS = 1 << DATA_W;
   localparam int HALF  = SLOTS / 2;

   logic [EW-1:0] w_e, s_e, early_half, late_half, lo_b, hi_b;

   assign w_e = {1'b0, width};
   assign s_e = {1'b0, slot};

   // which half of the centred pulse takes the odd slot
   generate
      if (LATE_BIAS) begin : g_late
         assign early_half = w_e >> 1;
      end else begin : g_early
         assign early_half = w_e - (w_e >> 1);
      end
   endgenerate

   assign late_half = w_e - early_half;

   always_comb begin
      unique case (place)
         PLACE_LEAD: begin
            lo_b = '0;
            hi_b = w_e;
         end
         PLACE_TRAIL: begin
            lo_b = EW'(SLOTS) - w_e;
            hi_b = EW'(SLOTS);
         end
         PLACE_CENTRE: begin
            lo_b = EW'(HALF) - early_half;
            hi_b = EW'(HALF) + late_half;
         end
         default: begin
            lo_b = '0;
            hi_b = '0;
         end
      endcase
   end

   assign hit = valid && (s_e >= lo_b) && (s_e < hi_b);

endmodule

// File: rtl/pulse_place_mod.sv
module pulse_place_mod
   import ppm_pkg::*;
#(
   parameter int DATA_W    = 6,
   parameter bit LATE_BIAS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data_word,
   input  logic              ctl_centre,
   input  logic              ctl_trail,
   input  logic              line_start,
   output logic              pwm_out
);
   localparam int SLOTS = 1 << DATA_W;
   localparam int HALF  = SLOTS / 2;
   localparam logic [DATA_W-1:0] LAST_SLOT = '1;

   generate
      if (DATA_W < 2 || DATA_W > 12) begin : g_bad_width
         $error("pulse_place_mod: DATA_W must lie in 2..12");
      end
   endgenerate

   logic [DATA_W-1:0] slot;
   logic              boundary;
   logic [DATA_W-1:0] width_q;
   place_e            place_q;
   logic              valid_q;
   logic              hit;

   ppm_slot_counter #(.DATA_W(DATA_W)) u_count (
      .clk        (clk),
      .rst        (rst),
      .line_start (line_start),
      .slot       (slot),
      .boundary   (boundary)
   );

   ppm_word_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .load      (boundary),
      .data_in   (data_word),
      .centre_in (ctl_centre),
      .trail_in  (ctl_trail),
      .width_q   (width_q),
      .place_q   (place_q),
      .valid_q   (valid_q)
   );

   ppm_window_cmp #(.DATA_W(DATA_W), .LATE_BIAS(LATE_BIAS)) u_win (
      .slot  (slot),
      .width (width_q),
      .place (place_q),
      .valid (valid_q),
      .hit   (hit)
   );

   always_ff @(posedge clk) begin
      if (rst) pwm_out <= 1'b0;
      else     pwm_out <= hit;
   end

   a_r8_low_in_reset: assert property (@(posedge clk)
      rst |=> !pwm_out);

   a_r8_low_before_first_word: assert property (@(posedge clk) disable iff (rst)
      !valid_q |=> !pwm_out);

   a_r4_zero_width_silent: assert property (@(posedge clk) disable iff (rst)
      (valid_q && width_q == '0) |=> !pwm_out);

   a_r1_lead_first_slot: assert property (@(posedge clk) disable iff (rst)
      (valid_q && place_q == PLACE_LEAD && width_q != '0 && slot == '0) |=> pwm_out);

   a_r2_trail_last_slot: assert property (@(posedge clk) disable iff (rst)
      (valid_q && place_q == PLACE_TRAIL && width_q != '0 && slot == LAST_SLOT) |=> pwm_out);

   a_r3_centre_before_mid: assert property (@(posedge clk) disable iff (rst)
      (valid_q && place_q == PLACE_CENTRE && width_q >= DATA_W'(2)
       && slot == DATA_W'(HALF - 1)) |=> pwm_out);

endmodule

// File: tb/tb_pulse_place_mod.sv
module tb_pulse_place_mod;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 6;

   logic          clk = 1'b0;
   logic          rst;
   logic [DW-1:0] data_word;
   logic          ctl_centre;
   logic          ctl_trail;
   logic          line_start;
   logic          pwm_out;

   int checks = 0;
   int errors = 0;

   logic [63:0] exp_q[$];
   string       tag_q[$];

   int s1_n [14] = '{10, 0, 63, 1, 63, 20, 0, 1, 2, 63, 0, 17, 32, 5};
   bit s1_c [14] = '{0,  0, 0,  0, 0,  0,  0, 1, 1, 1,  1, 1,  1,  0};
   bit s1_t [14] = '{0,  0, 0,  1, 1,  1,  1, 0, 0, 0,  0, 1,  0,  0};
   int s2_n [3]  = '{7, 40, 3};
   bit s2_c [3]  = '{0, 1, 0};
   bit s2_t [3]  = '{1, 0, 0};

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_place_mod #(.DATA_W(DW)) dut (
      .clk        (clk),
      .rst        (rst),
      .data_word  (data_word),
      .ctl_centre (ctl_centre),
      .ctl_trail  (ctl_trail),
      .line_start (line_start),
      .pwm_out    (pwm_out)
   );

   // expected slot pattern, bit s = slot s
   function automatic logic [63:0] slot_pattern(int n, bit c, bit t);
      logic [63:0] p = '0;
      for (int s = 0; s < 64; s++) begin
         if (c)      p[s] = (s >= 32 - n/2) && (s < 32 - n/2 + n);
         else if (t) p[s] = (s >= 64 - n);
         else        p[s] = (s < n);
      end
      return p;
   endfunction

   function automatic string tag_for(int n, bit c, bit t);
      if (n == 0)  return "R4";
      if (c && t)  return "R9";
      if (c)       return "R3";
      if (t)       return "R2";
      return "R1";
   endfunction

   task automatic check_bit(string tag, logic got, logic want);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: pwm_out=%b expected %b at %0t", tag, got, want, $time);
      end
   endtask

   // driver pushes expectations; monitor pops and compares whole periods (R5 order)
   task automatic run_stream(int cnt, bit second);
      fork
         begin : driver
            for (int i = 0; i < cnt; i++) begin
               int n; bit c; bit t;
               n = second ? s2_n[i] : s1_n[i];
               c = second ? s2_c[i] : s1_c[i];
               t = second ? s2_t[i] : s1_t[i];
               data_word  = DW'(n);
               ctl_centre = c;
               ctl_trail  = t;
               line_start = (i == 0);
               exp_q.push_back(slot_pattern(n, c, t));
               tag_q.push_back((second && i == 0) ? "R7" : tag_for(n, c, t));
               @(negedge clk);
               line_start = 1'b0;
               repeat (29) @(negedge clk);
               // R6: disturb every input mid-period
               data_word  = ~data_word;
               ctl_centre = ~ctl_centre;
               ctl_trail  = ~ctl_trail;
               repeat (34) @(negedge clk);
            end
         end
         begin : monitor
            @(negedge clk);
            for (int i = 0; i < cnt; i++) begin
               logic [63:0] got, want;
               string tag;
               for (int k = 0; k < 64; k++) begin
                  @(negedge clk);
                  got[k] = pwm_out;
               end
               want = exp_q.pop_front();
               tag  = tag_q.pop_front();
               checks++;
               if (got !== want) begin
                  errors++;
                  $display("FAIL %s (R5/R6) period %0d: got %h expected %h", tag, i, got, want);
               end
            end
         end
      join
   endtask

   initial begin
      rst        = 1'b1;
      data_word  = 6'd63;
      ctl_centre = 1'b0;
      ctl_trail  = 1'b0;
      line_start = 1'b0;
      // R8: low while reset is held
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check_bit("R8 reset", pwm_out, 1'b0);
      end
      rst = 1'b0;
      // R8: first 64 slots after reset stay low though width 63 lead is offered
      begin
         logic any_high = 1'b0;
         for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            any_high |= pwm_out;
         end
         check_bit("R8 first period", any_high, 1'b0);
      end
      run_stream(14, 1'b0);
      // let the counter drift into an unscored period, then strobe mid-period (R7)
      repeat (23) @(negedge clk);
      run_stream(3, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule